// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Rate Generator

This block is the periodic-event source of a legacy PC real-time clock. A 32.768 kHz time-base enable drives a binary divider chain. A 4-bit rate code selects one tap of that chain. Each time the selected tap completes a period, the block raises a one-cycle event pulse and sets a sticky periodic flag. The flag and its enable together form the interrupt request. The same tap also drives a square-wave output, which toggles every half period.

A 3-bit chain-control code chooses how the divider runs. It can count normally, or it can be held cleared. It also has test modes that skip the first 5, 10 or 15 stages, so that the slow taps can be exercised in a few ticks. The rate code, the chain code and the enables arrive as plain register fields. The host clears the flag with a one-cycle pulse, which stands for the read of the flag register. The bus interface, time-of-day counting and alarms are handled elsewhere.

Top module: `rtc_periodic_gen`

## Requirements
- R1: Rate code 0 disables the periodic function: no event pulse, the flag is never set, and the square wave stays low.
- R2: Rate codes 3 to 15 give a period of 2^(code-1) time-base ticks (code 3 = 4 ticks, code 15 = 16384 ticks). Each period ends with `per_pulse` high for exactly one clock, in the cycle after the clock edge of the tick that completes it.
- R3: Rate code 1 behaves exactly like code 8 (128 ticks), and rate code 2 behaves exactly like code 9 (256 ticks).
- R4: Chain code 3'b010 counts normally. Codes 3'b011, 3'b100 and 3'b101 skip 5, 10 and 15 low stages, so a period lasts 2^(code-1-k) ticks, with a minimum of 1 tick. Every other chain code (3'b000, 3'b001, 3'b110, 3'b111) holds the divider cleared and produces no events.
- R5: After the chain code leaves a held state into normal counting, the first event comes after exactly one full period of ticks, counted from the release.
- R6: When `sqw_en` is 1 and the rate code is non-zero, `sqw_out` starts low and toggles on every half-period boundary. Otherwise `sqw_out` is low at once, and the toggle phase restarts low.
- R7: Each event sets `per_flag` whatever the value of `pie_en`. The flag stays set until a `flag_clr` pulse. If an event and a clear fall in the same cycle, the event wins.
- R8: `irq` is high exactly when `per_flag` and `pie_en` are both 1, with no added delay.
- R9: While reset is asserted and after it is released, all outputs are low and the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle time-base enable at 32.768 kHz |
| rate_sel | input | 4 | Rate code selecting the divider tap |
| chain_sel | input | 3 | Divider chain control (run, hold, stage skip) |
| sqw_en | input | 1 | Square-wave output enable |
| pie_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | One-cycle clear of the periodic flag |
| per_pulse | output | 1 | One-cycle pulse per completed period |
| per_flag | output | 1 | Sticky periodic event flag |
| sqw_out | output | 1 | Square wave at the selected rate |
| irq | output | 1 | Periodic interrupt request |

## Verification
The assertions assume that `tick_32k` is never high on two consecutive clocks. This is what makes the single-cycle pulse property hold even when every tick is a period. The bench model counts ticks from the last release of the divider. It is exact only if the chain code goes from one counting mode to another through a held value. The stimulus therefore always passes through 3'b110 (or another hold code) between counting modes. It fires ticks every third clock and changes inputs only between clock edges.

// File: rtl/rtc_pir_pkg.sv
package rtc_pir_pkg;
  localparam int RATE_W  = 4;
  localparam int CHAIN_W = 3;
  localparam int SHIFT_W = 5;

  typedef struct packed {
    logic               run;
    logic [SHIFT_W-1:0] skip;
  } chain_cfg_t;

  // number of low divider bits that make up one full period
  function automatic logic [SHIFT_W-1:0] rate_tap(input logic [RATE_W-1:0] r);
    logic [SHIFT_W-1:0] t;
    case (r)
      4'd0:    t = '0;
      4'd1:    t = 5'd7;
      4'd2:    t = 5'd8;
      default: t = SHIFT_W'(r) - 5'd1;
    endcase
    return t;
  endfunction

  function automatic chain_cfg_t chain_decode(input logic [CHAIN_W-1:0] c);
    chain_cfg_t cfg;
    case (c)
      3'b010:  cfg = '{run: 1'b1, skip: 5'd0};
      3'b011:  cfg = '{run: 1'b1, skip: 5'd5};
      3'b100:  cfg = '{run: 1'b1, skip: 5'd10};
      3'b101:  cfg = '{run: 1'b1, skip: 5'd15};
      default: cfg = '{run: 1'b0, skip: 5'd0};
    endcase
    return cfg;
  endfunction
endpackage

// File: rtl/rtc_pir_decode.sv
module rtc_pir_decode
  import rtc_pir_pkg::*;
(
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic [CHAIN_W-1:0] chain_sel,
  output logic               active,
  output logic [SHIFT_W-1:0] per_bits,
  output logic [SHIFT_W-1:0] half_bits,
  output logic               run,
  output logic [SHIFT_W-1:0] skip
);
  chain_cfg_t cfg;

  always_comb begin
    cfg       = chain_decode(chain_sel);
    run       = cfg.run;
    skip      = cfg.skip;
    active    = (rate_sel != '0);
    per_bits  = rate_tap(rate_sel);
    half_bits = active ? (per_bits - 5'd1) : '0;
  end
endmodule

// File: rtl/rtc_pir_divider.sv
module rtc_pir_divider
  import rtc_pir_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               run,
  input  logic               active,
  input  logic [SHIFT_W-1:0] skip,
  input  logic [SHIFT_W-1:0] per_bits,
  input  logic [SHIFT_W-1:0] half_bits,
  output logic               period_hit,
  output logic               half_hit
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  function automatic logic [DIV_W-1:0] low_mask(input logic [SHIFT_W-1:0] n);
    return (ONE << n) - ONE;
  endfunction

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             step;

  // skipped stages behave as if their carry is always ready
  assign cnt_nxt    = (cnt_q | low_mask(skip)) + ONE;
  assign step       = tick & run;
  assign period_hit = step & active & ((cnt_nxt & low_mask(per_bits)) == '0);
  assign half_hit   = step & active & ((cnt_nxt & low_mask(half_bits)) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!run)    cnt_q <= '0;
    else if (step)    cnt_q <= cnt_nxt;
  end

  a_r2_full_implies_half: assert property (@(posedge clk) disable iff (!rst_n)
    period_hit |-> half_hit);

  a_r4_skip15_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && skip == 5'd15 && active && tick) |-> period_hit);
endmodule

// File: rtl/rtc_pir_outputs.sv
module rtc_pir_outputs (
  input  logic clk,
  input  logic rst_n,
  input  logic period_hit,
  input  logic half_hit,
  input  logic sq_gate,
  input  logic flag_clr,
  input  logic pie_en,
  output logic per_pulse,
  output logic per_flag,
  output logic sqw_out,
  output logic irq
);
  logic pulse_q, flag_q, sq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
      sq_q    <= 1'b0;
    end else begin
      pulse_q <= period_hit;
      if (period_hit)    flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (!sq_gate)      sq_q <= 1'b0;
      else if (half_hit) sq_q <= ~sq_q;
    end
  end

  assign per_pulse = pulse_q;
  assign per_flag  = flag_q;
  assign sqw_out   = sq_q & sq_gate;
  assign irq       = flag_q & pie_en;

  a_r7_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |-> per_flag);

  a_r7_clear_drops_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !period_hit) |=> !per_flag);

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    per_pulse |=> !per_pulse);

  a_r6_steady_between_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_gate && $past(sq_gate) && !$past(half_hit)) |-> $stable(sqw_out));
endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_pir_pkg::*;
#(
  parameter int DIV_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_32k,
  input  logic [RATE_W-1:0]  rate_sel,
  input  logic [CHAIN_W-1:0] chain_sel,
  input  logic               sqw_en,
  input  logic               pie_en,
  input  logic               flag_clr,
  output logic               per_pulse,
  output logic               per_flag,
  output logic               sqw_out,
  output logic               irq
);
  logic               active, run;
  logic [SHIFT_W-1:0] per_bits, half_bits, skip;
  logic               period_hit, half_hit;
  logic               sq_gate;

  assign sq_gate = sqw_en & active;

  rtc_pir_decode u_decode (
    .rate_sel  (rate_sel),
    .chain_sel (chain_sel),
    .active    (active),
    .per_bits  (per_bits),
    .half_bits (half_bits),
    .run       (run),
    .skip      (skip)
  );

  rtc_pir_divider #(.DIV_W(DIV_W)) u_divider (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_32k),
    .run        (run),
    .active     (active),
    .skip       (skip),
    .per_bits   (per_bits),
    .half_bits  (half_bits),
    .period_hit (period_hit),
    .half_hit   (half_hit)
  );

  rtc_pir_outputs u_outputs (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_hit (period_hit),
    .half_hit   (half_hit),
    .sq_gate    (sq_gate),
    .flag_clr   (flag_clr),
    .pie_en     (pie_en),
    .per_pulse  (per_pulse),
    .per_flag   (per_flag),
    .sqw_out    (sqw_out),
    .irq        (irq)
  );

  a_r1_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == '0) |=> !per_pulse);

  a_r4_hold_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_sel == 3'b110 || chain_sel == 3'b111) |=> !per_pulse);
endmodule

// File: tb/test_rtc_periodic_gen.sv
module test_rtc_periodic_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_32k = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic [2:0] chain_sel = 3'b110;
  logic       sqw_en = 1'b0;
  logic       pie_en = 1'b0;
  logic       flag_clr = 1'b0;
  logic       per_pulse, per_flag, sqw_out, irq;

  always #10 clk = ~clk;

  rtc_periodic_gen i_rtc_periodic_gen (
    .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
    .chain_sel(chain_sel), .sqw_en(sqw_en), .pie_en(pie_en), .flag_clr(flag_clr),
    .per_pulse(per_pulse), .per_flag(per_flag), .sqw_out(sqw_out), .irq(irq)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R9";
  bit    ticking = 1'b0;

  // behavioural reference
  longint t_since = 0;
  bit     e_pulse = 1'b0, e_flag = 1'b0, e_sq = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      t_since = 0;
      e_pulse <= 1'b0; e_flag <= 1'b0; e_sq <= 1'b0;
    end else begin
      bit hit, half, counting, gate;
      int k, n;
      longint per, pos;
      hit = 1'b0; half = 1'b0;
      counting = (chain_sel >= 3'd2 && chain_sel <= 3'd5);
      k = (chain_sel == 3'd3) ? 5 : (chain_sel == 3'd4) ? 10 : (chain_sel == 3'd5) ? 15 : 0;
      n = (rate_sel == 4'd1) ? 8 : (rate_sel == 4'd2) ? 9 : int'(rate_sel);
      if (!counting) t_since = 0;
      else if (tick_32k) begin
        t_since++;
        if (rate_sel != 4'd0) begin
          per  = longint'(1) << (n - 1);
          pos  = t_since << k;
          hit  = (pos % per) == 0;
          half = (pos % (per / 2)) == 0;
        end
      end
      gate = sqw_en && (rate_sel != 4'd0);
      e_pulse <= hit;
      e_flag  <= hit ? 1'b1 : (flag_clr ? 1'b0 : e_flag);
      e_sq    <= !gate ? 1'b0 : (half ? ~e_sq : e_sq);
    end
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    check(tag, "per_pulse", per_pulse, e_pulse);
    check(tag, "per_flag",  per_flag,  e_flag);
    check(tag, "sqw_out",   sqw_out,   e_sq & sqw_en & (rate_sel != 4'd0));
    check(tag, "irq",       irq,       e_flag & pie_en);
  end

  // time-base: one tick every third clock
  initial begin
    int div = 0;
    forever begin
      @(negedge clk); #2;
      tick_32k = ticking && (div == 2);
      div = (div + 1) % 3;
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n * 3) @(negedge clk);
  endtask

  task automatic setup(input logic [2:0] c, input logic [3:0] r);
    @(negedge clk); #3;
    chain_sel = c; rate_sel = r;
  endtask

  task automatic clear_flag();
    @(negedge clk); #3 flag_clr = 1'b1;
    @(negedge clk); #3 flag_clr = 1'b0;
  endtask

  task automatic hold_then(input logic [2:0] c, input logic [3:0] r);
    setup(3'b110, r);
    wait_ticks(2);
    setup(c, r);
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int cnt;
    repeat (5) @(negedge clk);
    tag = "R9";
    check("R9", "reset per_flag", per_flag, 1'b0);
    check("R9", "reset sqw_out", sqw_out, 1'b0);
    #3 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", "post-reset per_pulse", per_pulse, 1'b0);
    check("R9", "post-reset irq", irq, 1'b0);
    ticking = 1'b1;

    // R5: first event one full period after release (code 6 = 32 ticks)
    tag = "R5";
    sqw_en = 1'b1; pie_en = 1'b1;
    setup(3'b110, 4'd6);
    wait_ticks(3);
    setup(3'b010, 4'd6);
    cnt = 0;
    for (int i = 0; i < 200; i++) begin
      @(posedge clk);
      if (tick_32k) cnt++;
      @(negedge clk);
      if (per_pulse) break;
    end
    n_cmp++;
    if (cnt != 32) begin
      n_bad++;
      $display("FAIL R5 ticks to first event: actual %0d expected 32", cnt);
    end

    tag = "R2";
    setup(3'b010, 4'd3);  wait_ticks(40);
    setup(3'b010, 4'd4);  wait_ticks(40);
    setup(3'b010, 4'd7);  wait_ticks(200);

    tag = "R6";
    sqw_en = 1'b0; wait_ticks(20);
    setup(3'b010, 4'd3); sqw_en = 1'b1; wait_ticks(30);

    tag = "R3";
    setup(3'b010, 4'd1);  wait_ticks(300);
    setup(3'b010, 4'd8);  wait_ticks(300);
    setup(3'b010, 4'd2);  wait_ticks(600);

    tag = "R1";
    setup(3'b010, 4'd0);
    clear_flag();
    wait_ticks(200);
    check("R1", "code 0 flag stays clear", per_flag, 1'b0);
    check("R1", "code 0 square low", sqw_out, 1'b0);

    tag = "R4";
    hold_then(3'b011, 4'd10); wait_ticks(100);
    hold_then(3'b100, 4'd15); wait_ticks(100);
    hold_then(3'b101, 4'd5);  wait_ticks(40);
    hold_then(3'b101, 4'd15); wait_ticks(20);
    setup(3'b000, 4'd3);
    clear_flag();
    wait_ticks(30);
    check("R4", "chain 000 holds, flag clear", per_flag, 1'b0);
    setup(3'b001, 4'd3); wait_ticks(20);
    check("R4", "chain 001 holds, flag clear", per_flag, 1'b0);
    setup(3'b111, 4'd3); wait_ticks(20);
    check("R4", "chain 111 holds, flag clear", per_flag, 1'b0);

    tag = "R7";
    pie_en = 1'b0;
    setup(3'b010, 4'd3);
    wait_ticks(10);
    check("R7", "flag set with enable off", per_flag, 1'b1);
    tag = "R8";
    check("R8", "irq blocked by enable", irq, 1'b0);
    pie_en = 1'b1;
    @(negedge clk);
    check("R8", "irq follows flag", irq, 1'b1);
    tag = "R7";
    for (int j = 0; j < 20; j++) begin
      clear_flag();
      wait_ticks(1);
    end
    hold_then(3'b101, 4'd9);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk); #3 flag_clr = 1'b1;
      repeat (3) @(negedge clk);
      #3 flag_clr = 1'b0;
      @(negedge clk);
    end
    tag = "R8";
    pie_en = 1'b0; wait_ticks(5);
    pie_en = 1'b1; wait_ticks(5);

    ticking = 1'b0;
    repeat (5) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule